// File: doc/BRIEF.md
# Timer Overflow Interrupt Sequencer

This block pairs an 8-bit up-counter with the logic that turns its wrap-around into a vectored interrupt entry. It is meant for a processor whose instruction cycle spans four oscillator clocks. The block generates the four phase strobes itself. The counter advances once per instruction cycle. When it wraps from its all-ones value to zero, it raises a sticky overflow flag.

A small control register holds three bits: the flag, a per-source enable and a global enable. The request is examined only in the first phase of each instruction cycle. If it is accepted, the block does three things:
- it lets the current instruction cycle finish;
- it marks the next two instruction cycles as dummy cycles;
- it pulses a program-counter load with the fixed vector, while presenting the interrupted flow's PC as a return address for a stack.

Software reaches the counter and the control bits through a simple write port, and reads them back on dedicated outputs. A sleep input freezes the counter, so this source can never wake the core.

Top module: `tmr_irq_seq`

## Requirements
- R1: Each instruction cycle is four clocks. `phase_o` is one-hot, with bit0 = Q1, bit1 = Q2, bit2 = Q3 and bit3 = Q4. Reset leaves it at Q1, and it steps Q1, Q2, Q3, Q4, Q1 and so on.
- R2: While not sleeping, the counter increments by one on the clock edge that ends Q4 and holds at every other edge. It wraps from FFh to 00h.
- R3: A write with `wr_sel`=0 loads `wr_data` into the counter at that edge. The next Q4 increment after the write is skipped.
- R4: A wrap from FFh to 00h sets the overflow flag (control bit 2), whatever the enable bits hold.
- R5: Hardware never clears the flag. Only a control write (`wr_sel`=1) with bit 2 = 0 clears it.
- R6: While `sleep_i` is high, the counter holds its value, so no overflow and no flag can come from it.
- R7: The request is examined only on the edge that ends Q1. It is taken only when global enable (control bit 0), source enable (control bit 1) and the flag are all 1.
- R8: Taking the interrupt clears the global enable on that same Q1 edge. No further entry occurs until software sets it again.
- R9: The instruction cycle in which the request was taken completes normally. `dummy_o` is then high for all eight clocks of the next two instruction cycles, and low otherwise.
- R10: `pc_load_o` pulses for one clock in Q4 of the second dummy cycle, with `pc_vec_o` = 004h. `ret_addr_o` then shows the `pc_i` value sampled at the end of the cycle that took the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_i | input | 1 | Core is sleeping; counter frozen |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = counter, 1 = control register |
| wr_data | input | 8 | Write data (control: bit0 global enable, bit1 source enable, bit2 flag) |
| pc_i | input | 13 | Current program counter of the core |
| phase_o | output | 4 | One-hot phase strobes Q1..Q4 |
| tmr_o | output | 8 | Counter value |
| gie_o | output | 1 | Global interrupt enable |
| ovf_en_o | output | 1 | Overflow interrupt enable |
| ovf_flag_o | output | 1 | Overflow flag |
| dummy_o | output | 1 | Current instruction cycle is a dummy cycle |
| pc_load_o | output | 1 | Load the PC with `pc_vec_o` |
| pc_vec_o | output | 13 | Interrupt vector (004h) |
| ret_addr_o | output | 13 | Return address for the stack |

## Verification
Several rules are checked on every clock:
- the phase sequence;
- the counter holding outside Q4 and during sleep;
- loads landing on the next edge;
- a wrap always raising the flag;
- the flag only falling on a clearing write;
- acceptance only in Q1 and the global enable dropping right after it;
- the vector load only in Q4 of a dummy cycle.

Other behaviours need a whole scenario, and only the bench scenarios show them:
- the exact two-cycle dummy window and the clock on which the load lands;
- the return address being frozen before the PC moves on;
- the skipped increment after a counter write;
- masking by either enable;
- the absence of any entry while asleep.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
   localparam int PHASES    = 4;
   localparam int PH_W      = 2;
   localparam int CTRL_GIE  = 0;
   localparam int CTRL_EN   = 1;
   localparam int CTRL_FLAG = 2;
   localparam int CTRL_W    = 3;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_FINISH = 2'd1,
      SQ_DUMMY  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/phase_gen.sv
module phase_gen
   import tmr_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   output logic [PHASES-1:0] q_o
);
   logic [PH_W-1:0] ph;

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= '0;
      else        ph <= ph + 1'b1;
   end

   for (genvar gi = 0; gi < PHASES; gi++) begin : g_strobe
      assign q_o[gi] = (ph == PH_W'(gi));
   end

   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_o[PHASES-1] |=> q_o[0]);
   // R1
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_o[0] |=> q_o[1]);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         q4,
   input  logic         sleep_i,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] tmr_o,
   output logic         ovf_o
);
   logic skip;
   logic step;

   assign step  = q4 && !ld && !skip && !sleep_i;
   assign ovf_o = step && (tmr_o == {W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tmr_o <= '0;
         skip  <= 1'b0;
      end else if (ld) begin
         tmr_o <= ld_val;
         skip  <= 1'b1;
      end else if (q4) begin
         skip <= 1'b0;
         if (step) tmr_o <= tmr_o + 1'b1;
      end
   end

   // R2
   hold_off_q4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!q4 && !ld) |=> $stable(tmr_o));
   // R3
   load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (tmr_o == $past(ld_val)));
   // R6
   sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !ld) |=> $stable(tmr_o));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import tmr_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wd,
   input  logic              hw_set,
   input  logic              take,
   output logic              gie_o,
   output logic              en_o,
   output logic              flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_o  <= 1'b0;
         en_o   <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         if (wr) begin
            gie_o  <= wd[CTRL_GIE];
            en_o   <= wd[CTRL_EN];
            flag_o <= wd[CTRL_FLAG] | hw_set;
         end else if (hw_set) begin
            flag_o <= 1'b1;
         end
         if (take) gie_o <= 1'b0;
      end
   end

   // R4
   wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag_o);
   // R5
   flag_sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(wr && !wd[CTRL_FLAG]));
endmodule

// File: rtl/entry_seq.sv
module entry_seq
   import tmr_irq_pkg::*;
#(
   parameter int PC_W    = 13,
   parameter int VECTOR  = 4,
   parameter int DUMMY_N = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            q1,
   input  logic            q4,
   input  logic            gie,
   input  logic            en,
   input  logic            flag,
   input  logic [PC_W-1:0] pc_i,
   output logic            take_o,
   output logic            dummy_o,
   output logic            pc_load_o,
   output logic [PC_W-1:0] pc_vec_o,
   output logic [PC_W-1:0] ret_addr_o
);
   localparam int DW = (DUMMY_N < 2) ? 1 : $clog2(DUMMY_N);
   localparam logic [DW-1:0] LAST = DW'(DUMMY_N - 1);

   seq_state_t      st;
   logic [DW-1:0]   dcnt;
   logic            last_dummy;

   assign take_o     = (st == SQ_IDLE) && q1 && gie && en && flag;
   assign dummy_o    = (st == SQ_DUMMY);
   assign last_dummy = dummy_o && (dcnt == LAST);
   assign pc_load_o  = last_dummy && q4;
   assign pc_vec_o   = PC_W'(VECTOR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         dcnt       <= '0;
         ret_addr_o <= '0;
      end else begin
         case (st)
            SQ_IDLE:   if (take_o) st <= SQ_FINISH;
            SQ_FINISH: if (q4) begin
                          st         <= SQ_DUMMY;
                          dcnt       <= '0;
                          ret_addr_o <= pc_i;
                       end
            SQ_DUMMY:  if (q4) begin
                          if (dcnt == LAST) st <= SQ_IDLE;
                          else              dcnt <= dcnt + 1'b1;
                       end
            default:   st <= SQ_IDLE;
         endcase
      end
   end

   // R7
   take_in_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (q1 && gie && en && flag));
   // R9
   dummy_starts_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dummy_o) |-> $past(q4));
   // R10
   load_in_dummy_q4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (dummy_o && q4 && pc_vec_o == PC_W'(VECTOR)));
endmodule

// File: rtl/tmr_irq_seq.sv
module tmr_irq_seq
   import tmr_irq_pkg::*;
#(
   parameter int TMR_W   = 8,
   parameter int PC_W    = 13,
   parameter int VECTOR  = 4,
   parameter int DUMMY_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [TMR_W-1:0]  wr_data,
   input  logic [PC_W-1:0]   pc_i,
   output logic [PHASES-1:0] phase_o,
   output logic [TMR_W-1:0]  tmr_o,
   output logic              gie_o,
   output logic              ovf_en_o,
   output logic              ovf_flag_o,
   output logic              dummy_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_vec_o,
   output logic [PC_W-1:0]   ret_addr_o
);
   if (TMR_W < CTRL_W) begin : g_bad_width
      $error("TMR_W must cover the control bits");
   end
   if (DUMMY_N < 1) begin : g_bad_dummy
      $error("DUMMY_N must be at least 1");
   end
   if (VECTOR >= (1 << PC_W)) begin : g_bad_vec
      $error("VECTOR does not fit in PC_W");
   end

   logic ovf;
   logic take;

   phase_gen u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .q_o   (phase_o)
   );

   tmr_core #(.W(TMR_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .q4      (phase_o[PHASES-1]),
      .sleep_i (sleep_i),
      .ld      (wr_en && !wr_sel),
      .ld_val  (wr_data),
      .tmr_o   (tmr_o),
      .ovf_o   (ovf)
   );

   irq_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en && wr_sel),
      .wd     (wr_data[CTRL_W-1:0]),
      .hw_set (ovf),
      .take   (take),
      .gie_o  (gie_o),
      .en_o   (ovf_en_o),
      .flag_o (ovf_flag_o)
   );

   entry_seq #(
      .PC_W    (PC_W),
      .VECTOR  (VECTOR),
      .DUMMY_N (DUMMY_N)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .q1         (phase_o[0]),
      .q4         (phase_o[PHASES-1]),
      .gie        (gie_o),
      .en         (ovf_en_o),
      .flag       (ovf_flag_o),
      .pc_i       (pc_i),
      .take_o     (take),
      .dummy_o    (dummy_o),
      .pc_load_o  (pc_load_o),
      .pc_vec_o   (pc_vec_o),
      .ret_addr_o (ret_addr_o)
   );

   // R8
   gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !gie_o);
endmodule

// File: tb/tmr_irq_seq_test.sv
module tmr_irq_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_i = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [12:0] pc_i = '0;
   logic [3:0]  phase_o;
   logic [7:0]  tmr_o;
   logic        gie_o, ovf_en_o, ovf_flag_o, dummy_o, pc_load_o;
   logic [12:0] pc_vec_o, ret_addr_o;

   int checks = 0;
   int failures = 0;
   int dummy_seen = 0;
   int load_seen = 0;
   bit done = 0;

   tmr_irq_seq uut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .pc_i(pc_i), .phase_o(phase_o),
      .tmr_o(tmr_o), .gie_o(gie_o), .ovf_en_o(ovf_en_o),
      .ovf_flag_o(ovf_flag_o), .dummy_o(dummy_o), .pc_load_o(pc_load_o),
      .pc_vec_o(pc_vec_o), .ret_addr_o(ret_addr_o)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (dummy_o)   dummy_seen++;
      if (pc_load_o) load_seen++;
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic to_phase(int p);
      while (phase_o != (4'b0001 << p)) tick();
   endtask

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) begin
         to_phase(1);
         to_phase(0);
      end
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic t_reset();
      chk("R1 reset phase", int'(phase_o), 1);
      chk("R2 reset counter", int'(tmr_o), 0);
      chk("R5 reset flag", int'(ovf_flag_o), 0);
      chk("R9 reset dummy", int'(dummy_o), 0);
      tick();
      chk("R1 second phase", int'(phase_o), 2);
      tick(); tick();
      chk("R1 fourth phase", int'(phase_o), 8);
   endtask

   task automatic t_count();
      to_phase(1);
      wr(1'b0, 8'h10);
      chk("R3 load value", int'(tmr_o), 'h10);
      to_phase(0);
      chk("R3 increment skipped", int'(tmr_o), 'h10);
      cycles(1);
      chk("R2 first increment", int'(tmr_o), 'h11);
      to_phase(2);
      chk("R2 holds mid-cycle", int'(tmr_o), 'h11);
      to_phase(0);
      cycles(3);
      chk("R2 steady count", int'(tmr_o), 'h15);
   endtask

   task automatic t_masked();
      int d0;
      wr(1'b1, 8'h01);
      to_phase(1);
      wr(1'b0, 8'hFE);
      d0 = dummy_seen;
      to_phase(0);
      cycles(1);
      chk("R4 no flag before wrap", int'(ovf_flag_o), 0);
      cycles(1);
      chk("R2 wrap to zero", int'(tmr_o), 0);
      chk("R4 flag set with source disabled", int'(ovf_flag_o), 1);
      cycles(4);
      chk("R7 masked by source enable", dummy_seen - d0, 0);
      wr(1'b1, 8'h06);
      d0 = dummy_seen;
      cycles(4);
      chk("R7 masked by global enable", dummy_seen - d0, 0);
      cycles(10);
      chk("R5 flag sticky", int'(ovf_flag_o), 1);
      wr(1'b1, 8'h02);
      chk("R5 software clear", int'(ovf_flag_o), 0);
   endtask

   task automatic t_sequence();
      int bad_dummy = 0;
      int bad_load = 0;
      wr(1'b1, 8'h00);
      pc_i = 13'h123;
      to_phase(1);
      wr(1'b1, 8'h07);
      for (int i = 1; i <= 16; i++) begin
         if (int'(dummy_o) != ((i >= 7 && i <= 14) ? 1 : 0)) bad_dummy++;
         if (int'(pc_load_o) != ((i == 14) ? 1 : 0)) bad_load++;
         if (i == 3) chk("R8 enable held before Q1 edge", int'(gie_o), 1);
         if (i == 4) chk("R8 enable cleared on take", int'(gie_o), 0);
         if (i == 6) chk("R9 sampling cycle not dummy", int'(dummy_o), 0);
         if (i == 8) pc_i = 13'h155;
         if (i == 14) begin
            chk("R10 vector value", int'(pc_vec_o), 4);
            chk("R10 return address", int'(ret_addr_o), 'h123);
            chk("R1 load in Q4", int'(phase_o), 8);
         end
         tick();
      end
      chk("R9 dummy window", bad_dummy, 0);
      chk("R10 load pulse timing", bad_load, 0);
   endtask

   task automatic t_no_reentry();
      int d0, l0;
      d0 = dummy_seen; l0 = load_seen;
      cycles(6);
      chk("R8 no re-entry while disabled", dummy_seen - d0, 0);
      chk("R5 flag kept after entry", int'(ovf_flag_o), 1);
      wr(1'b1, 8'h07);
      cycles(6);
      chk("R8 re-entry after enable set", dummy_seen - d0, 8);
      chk("R10 single load per entry", load_seen - l0, 1);
   endtask

   task automatic t_sleep();
      int d0, l0;
      wr(1'b1, 8'h03);
      sleep_i = 1'b1;
      to_phase(1);
      wr(1'b0, 8'hFF);
      d0 = dummy_seen; l0 = load_seen;
      cycles(6);
      chk("R6 counter frozen", int'(tmr_o), 'hFF);
      chk("R6 no flag in sleep", int'(ovf_flag_o), 0);
      chk("R6 no entry in sleep", dummy_seen - d0, 0);
      sleep_i = 1'b0;
      cycles(1);
      chk("R6 resumes and wraps", int'(tmr_o), 0);
      chk("R4 flag on wake wrap", int'(ovf_flag_o), 1);
      cycles(5);
      chk("R9 overflow-driven entry", dummy_seen - d0, 8);
      chk("R10 overflow-driven load", load_seen - l0, 1);
      chk("R8 enable dropped", int'(gie_o), 0);
   endtask

   initial begin
      repeat (4) tick();
      rst_n = 1'b1;
      t_reset();
      t_count();
      t_masked();
      t_sequence();
      t_no_reentry();
      t_sleep();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule